// File: doc/BRIEF.md
# Dual Alarm Matcher and Interrupt Router

This block holds two programmable time-of-day/date alarms for a real-time clock. On each once-per-second update strobe it compares the current time bytes (seconds, minutes, hours, day-of-week, date) with the alarm bytes. A match raises a sticky alarm flag. The first alarm covers seconds, minutes, hours and day/date. The second alarm has no seconds field and is only ever tested at second 00. Bit 7 of each alarm byte is a mask bit, and the combination of mask bits selects the repeat rate.

The flags go to two active-low open-drain pins, each modelled as an output enable that pulls the pin low. A control bit chooses the routing. In one setting each alarm has its own pin. In the other, both alarms share the first pin and the second pin carries a square wave divided from a 32.768 kHz reference. A sticky oscillator-fail flag is also kept here. External logic sets it, and so does turning off the chain-enable bit.

Register access over the serial bus lives outside this block. The bus logic writes the control byte through a write strobe and clears flags through status writes.

Top module: `rtc_alarm_router`

## Requirements
- R1: After reset the control byte reads 18h, the status byte reads 80h (fail flag bit 7 set, alarm flags bits 1:0 clear), intaOe is 0, and the second pin carries the square wave.
- R2: Alarm 1 sets status bit 0 in the cycle after a secTick whose time matches, and only on secTick. Its masks {day/date bit 7, hour bit 7, min bit 7, sec bit 7} select the rate: 1111 every second, 1110 seconds, 1100 minutes and seconds, 1000 hours, minutes and seconds, 0000 full match including day/date.
- R3: Any other mask combination never sets a flag.
- R4: Alarm 2 sets status bit 1 only on a secTick whose seconds byte is 00. Its masks {day/date, hour, min} select the rate: 111 every minute, 110 minutes, 100 hours and minutes, 000 full match.
- R5: In the day/date alarm byte, bit 6 = 1 compares bits 5:0 with the day-of-week, and bit 6 = 0 compares them with the date.
- R6: Hour bytes are compared on bits 6:0, including the 12/24 mode bit, so an alarm written in the other hour mode never matches.
- R7: A status write of 0 to a flag bit clears it, and writing 1 leaves it unchanged. A match in the same cycle as a clear wins.
- R8: With control bit 2 (route) = 1, alarm 1 drives intaOe and alarm 2 drives intbOe. With route = 0, either alarm drives intaOe and intbOe carries the inverted square wave.
- R9: An alarm reaches a pin only when its enable is 1 (control bit 0 for alarm 1, bit 1 for alarm 2).
- R10: Control bits 4:3 pick the square wave: 00 gives the reference divided by 2^DIV_W, 01 gives divided by 8, 10 gives divided by 4, and 11 gives the reference itself.
- R11: Status bit 7 is set by oscFail or by control bit 7 = 1, cleared by writing 0 to it, and the set wins.
- R12: Control bits 6:5 read 0. Control bit 7 = 1 halts the divider and releases the square wave (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | Once-per-second update strobe |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours byte with mode bit 6 |
| curDay | input | 8 | Current day of week |
| curDate | input | 8 | Current date, BCD |
| a1Sec | input | 8 | Alarm 1 seconds byte, bit 7 mask |
| a1Min | input | 8 | Alarm 1 minutes byte, bit 7 mask |
| a1Hour | input | 8 | Alarm 1 hours byte, bit 7 mask |
| a1DayDate | input | 8 | Alarm 1 day/date byte, bit 7 mask, bit 6 select |
| a2Min | input | 8 | Alarm 2 minutes byte, bit 7 mask |
| a2Hour | input | 8 | Alarm 2 hours byte, bit 7 mask |
| a2DayDate | input | 8 | Alarm 2 day/date byte, bit 7 mask, bit 6 select |
| ctrlWr | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte write value |
| statWr | input | 1 | Status write strobe (write 0 clears) |
| statWrData | input | 8 | Status write value |
| oscFail | input | 1 | Oscillator failure indication |
| refClk | input | 1 | 32.768 kHz reference level, synchronous to clk |
| ctrlQ | output | 8 | Control byte |
| statusQ | output | 8 | Status byte |
| intaOe | output | 1 | Drive first interrupt pin low |
| intbOe | output | 1 | Drive second pin low |

## Verification
The bench draws random times and alarm bytes, including every mask pattern. It often copies the current time into the alarm so that matches actually happen. A design that accepted an unlisted mask pattern would raise spurious flags. A design that let alarm 2 fire on any second would fire sixty times a minute.

Directed cases cover the following:
- the day-versus-date selector, which a swapped mux would get wrong;
- a 12-hour alarm against a 24-hour time, which matches if the mode bit is dropped;
- a clear colliding with a match, which loses the alarm if the clear has priority;
- a match held without the strobe, which a design that compares continuously would flag.

The square-wave rates are measured by counting edges, and a swapped divider tap would show up as the wrong count.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int BYTE_W   = 8;
  localparam int FIELDS   = 4;
  localparam int ALARMS   = 2;
  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h18;
  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h80;

  // strobes from control to datapath
  typedef struct packed {
    logic       cmpEn;
    logic       divRun;
    logic [1:0] rate;
  } dpCmd_t;

  // results from datapath to control
  typedef struct packed {
    logic [ALARMS-1:0] hit;
    logic              sqwLevel;
  } dpRsp_t;
endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] curSec,
  input  logic [BYTE_W-1:0] curMin,
  input  logic [BYTE_W-1:0] curHour,
  input  logic [BYTE_W-1:0] curDay,
  input  logic [BYTE_W-1:0] curDate,
  input  logic [BYTE_W-1:0] a1Sec,
  input  logic [BYTE_W-1:0] a1Min,
  input  logic [BYTE_W-1:0] a1Hour,
  input  logic [BYTE_W-1:0] a1DayDate,
  input  logic [BYTE_W-1:0] a2Min,
  input  logic [BYTE_W-1:0] a2Hour,
  input  logic [BYTE_W-1:0] a2DayDate,
  input  logic              refClk,
  output dpRsp_t            rsp
);
  localparam int TAP_DIV8 = $clog2(8) - 1;
  localparam int TAP_DIV4 = $clog2(4) - 1;
  localparam int TAP_SLOW = DIV_W - 1;
  localparam int MSK      = BYTE_W - 1;
  localparam int SEL      = BYTE_W - 2;

  // alarm bytes per alarm and field; alarm 2 gets a fixed 00 seconds field
  logic [BYTE_W-1:0] almB [ALARMS][FIELDS];
  assign almB[0][0] = a1Sec;
  assign almB[0][1] = a1Min;
  assign almB[0][2] = a1Hour;
  assign almB[0][3] = a1DayDate;
  assign almB[1][0] = '0;
  assign almB[1][1] = a2Min;
  assign almB[1][2] = a2Hour;
  assign almB[1][3] = a2DayDate;

  logic [ALARMS-1:0] hitVec;

  for (genvar g = 0; g < ALARMS; g++) begin : g_alarm
    logic [FIELDS-1:0] mask;
    logic [FIELDS-1:0] fieldOk;
    logic              maskLegal;
    logic [BYTE_W-1:0] ddRef;

    for (genvar f = 0; f < FIELDS; f++) begin : g_mask
      assign mask[f] = almB[g][f][MSK];
    end

    assign ddRef      = almB[g][3][SEL] ? curDay : curDate;
    assign fieldOk[0] = {1'b0, almB[g][0][MSK-1:0]} == curSec;
    assign fieldOk[1] = {1'b0, almB[g][1][MSK-1:0]} == curMin;
    assign fieldOk[2] = {1'b0, almB[g][2][MSK-1:0]} == curHour;
    assign fieldOk[3] = {2'b00, almB[g][3][SEL-1:0]} == ddRef;

    // legal masks form a thermometer from the seconds side
    always_comb begin
      maskLegal = 1'b0;
      for (int k = 0; k <= FIELDS; k++) begin
        if (mask == FIELDS'((1 << FIELDS) - (1 << k))) maskLegal = 1'b1;
      end
    end

    assign hitVec[g] = cmd.cmpEn & maskLegal & (&(fieldOk | mask));
  end

  // square wave divider
  logic             refQ, refPrev;
  logic [DIV_W-1:0] divCnt;
  logic             sqwSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ    <= 1'b0;
      refPrev <= 1'b0;
      divCnt  <= '0;
    end else begin
      refQ    <= refClk;
      refPrev <= refQ;
      if (cmd.divRun && refQ && !refPrev) divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (cmd.rate)
      2'b00:   sqwSel = divCnt[TAP_SLOW];
      2'b01:   sqwSel = divCnt[TAP_DIV8];
      2'b10:   sqwSel = divCnt[TAP_DIV4];
      default: sqwSel = refQ;
    endcase
  end

  assign rsp.hit      = hitVec;
  assign rsp.sqwLevel = cmd.divRun ? sqwSel : 1'b1;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.divRun |=> $stable(divCnt)); // R12
  AST_NO_HIT_OFF_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (rsp.hit != '0) |-> cmd.cmpEn); // R2
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              ctrlWr,
  input  logic [BYTE_W-1:0] ctrlWrData,
  input  logic              statWr,
  input  logic [BYTE_W-1:0] statWrData,
  input  logic              oscFail,
  input  dpRsp_t            rsp,
  output dpCmd_t            cmd,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [BYTE_W-1:0] statusQ,
  output logic              intaOe,
  output logic              intbOe
);
  localparam logic [BYTE_W-1:0] CTRL_LIVE = 8'h9F;
  localparam logic [BYTE_W-1:0] STAT_KEEP = 8'h7C;

  logic [BYTE_W-1:0] ctrlReg;
  logic              a1f, a2f, osf;
  logic [BYTE_W-1:0] keepBits;
  logic              routeSplit, ie1, ie2;

  assign keepBits   = (statWr ? statWrData : '1) | STAT_KEEP;
  assign routeSplit = ctrlReg[2];
  assign ie1        = ctrlReg[0];
  assign ie2        = ctrlReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      a1f     <= STAT_RESET[0];
      a2f     <= STAT_RESET[1];
      osf     <= STAT_RESET[7];
    end else begin
      if (ctrlWr) ctrlReg <= ctrlWrData;
      a1f <= (a1f & keepBits[0]) | rsp.hit[0];
      a2f <= (a2f & keepBits[1]) | rsp.hit[1];
      osf <= (osf & keepBits[7]) | oscFail | ctrlReg[7];
    end
  end

  assign cmd.cmpEn  = secTick;
  assign cmd.divRun = ~ctrlReg[7];
  assign cmd.rate   = ctrlReg[4:3];

  assign ctrlQ   = ctrlReg & CTRL_LIVE;
  assign statusQ = {osf, 5'b00000, a2f, a1f};

  always_comb begin
    if (routeSplit) begin
      intaOe = a1f & ie1;
      intbOe = a2f & ie2;
    end else begin
      intaOe = (a1f & ie1) | (a2f & ie2);
      intbOe = ~rsp.sqwLevel;
    end
  end

  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(a1f) || $rose(a2f)) |-> $past(secTick)); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !statWrData[0] && !secTick) |=> !statusQ[0]); // R7
  AST_OSF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (osf && !(statWr && !statWrData[7])) |=> statusQ[7]); // R11
  AST_INTA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    intaOe |-> (statusQ[1:0] != 2'b00)); // R9
  AST_INTB_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[2] && intbOe) |-> statusQ[1]); // R8
endmodule

// File: rtl/rtc_alarm_router.sv
module rtc_alarm_router
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [7:0] curSec,
  input  logic [7:0] curMin,
  input  logic [7:0] curHour,
  input  logic [7:0] curDay,
  input  logic [7:0] curDate,
  input  logic [7:0] a1Sec,
  input  logic [7:0] a1Min,
  input  logic [7:0] a1Hour,
  input  logic [7:0] a1DayDate,
  input  logic [7:0] a2Min,
  input  logic [7:0] a2Hour,
  input  logic [7:0] a2DayDate,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlWrData,
  input  logic       statWr,
  input  logic [7:0] statWrData,
  input  logic       oscFail,
  input  logic       refClk,
  output logic [7:0] ctrlQ,
  output logic [7:0] statusQ,
  output logic       intaOe,
  output logic       intbOe
);
  dpCmd_t cmd;
  dpRsp_t rsp;

  rtc_alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .statWr(statWr), .statWrData(statWrData),
    .oscFail(oscFail), .rsp(rsp), .cmd(cmd),
    .ctrlQ(ctrlQ), .statusQ(statusQ), .intaOe(intaOe), .intbOe(intbOe)
  );

  rtc_alarm_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curDate(curDate),
    .a1Sec(a1Sec), .a1Min(a1Min), .a1Hour(a1Hour), .a1DayDate(a1DayDate),
    .a2Min(a2Min), .a2Hour(a2Hour), .a2DayDate(a2DayDate),
    .refClk(refClk), .rsp(rsp)
  );
endmodule

// File: tb/rtc_alarm_router_tb.sv
`timescale 1ns/1ps
module rtc_alarm_router_tb_top;
  logic clk = 1'b0, rstN = 1'b0, secTick = 1'b0, refClk = 1'b0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0, curDay = 8'h01, curDate = 8'h01;
  logic [7:0] a1Sec = 0, a1Min = 0, a1Hour = 0, a1DayDate = 0;
  logic [7:0] a2Min = 0, a2Hour = 0, a2DayDate = 0;
  logic ctrlWr = 0, statWr = 0, oscFail = 0;
  logic [7:0] ctrlWrData = 0, statWrData = 0;
  logic [7:0] ctrlQ, statusQ;
  logic intaOe, intbOe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  initial forever begin @(negedge clk); refClk = ~refClk; end

  rtc_alarm_router dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic bit expA1(input logic [7:0] s, m, h, dy, dt, as, am, ah, ad);
    bit sOk = as[6:0] == s[6:0];
    bit mOk = am[6:0] == m[6:0];
    bit hOk = ah[6:0] == h[6:0];
    bit dOk = ad[6] ? (ad[5:0] == dy[5:0]) : (ad[5:0] == dt[5:0]);
    case ({ad[7], ah[7], am[7], as[7]})
      4'b1111: return 1;
      4'b1110: return sOk;
      4'b1100: return sOk && mOk;
      4'b1000: return sOk && mOk && hOk;
      4'b0000: return sOk && mOk && hOk && dOk;
      default: return 0;
    endcase
  endfunction

  function automatic bit expA2(input logic [7:0] s, m, h, dy, dt, am, ah, ad);
    bit zOk = s == 8'h00;
    bit mOk = am[6:0] == m[6:0];
    bit hOk = ah[6:0] == h[6:0];
    bit dOk = ad[6] ? (ad[5:0] == dy[5:0]) : (ad[5:0] == dt[5:0]);
    case ({ad[7], ah[7], am[7]})
      3'b111: return zOk;
      3'b110: return zOk && mOk;
      3'b100: return zOk && mOk && hOk;
      3'b000: return zOk && mOk && hOk && dOk;
      default: return 0;
    endcase
  endfunction

  task automatic wrCtrl(input logic [7:0] v);
    ctrlWr = 1; ctrlWrData = v; @(negedge clk); ctrlWr = 0;
  endtask
  task automatic clrFlags();
    statWr = 1; statWrData = 8'h80; @(negedge clk); statWr = 0;
  endtask
  task automatic tick();
    secTick = 1; @(negedge clk); secTick = 0;
  endtask

  task automatic countEdges(input int cycles, output int n);
    logic prev = ~intbOe;
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (~intbOe && !prev) n++;
      prev = ~intbOe;
    end
  endtask

  task automatic alarmCase(input string req);
    bit e1, e2, ea, eb;
    clrFlags();
    tick();
    e1 = expA1(curSec, curMin, curHour, curDay, curDate, a1Sec, a1Min, a1Hour, a1DayDate);
    e2 = expA2(curSec, curMin, curHour, curDay, curDate, a2Min, a2Hour, a2DayDate);
    check(statusQ[1:0] == {e2, e1}, req, statusQ[1:0], {e2, e1});
    ea = ctrlQ[2] ? (e1 && ctrlQ[0]) : ((e1 && ctrlQ[0]) || (e2 && ctrlQ[1]));
    check(intaOe == ea, {req, " R8 R9 inta"}, intaOe, ea);
    if (ctrlQ[2]) begin
      eb = e2 && ctrlQ[1];
      check(intbOe == eb, {req, " R8 intb"}, intbOe, eb);
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(ctrlQ == 8'h18, "R1 ctrl", ctrlQ, 8'h18);
    check(statusQ == 8'h80, "R1 status", statusQ, 8'h80);
    check(intaOe == 0, "R1 inta", intaOe, 0);
    // R10 slow rate: divider keeps counting from reset
    wrCtrl(8'h00);
    repeat (29990) @(negedge clk);
    check(intbOe == 1, "R10 slow low half", intbOe, 1);
    repeat (4000) @(negedge clk);
    check(intbOe == 0, "R10 slow high half", intbOe, 0);
    // R10 fast rates
    wrCtrl(8'h18); countEdges(800, n);
    check(n >= 399 && n <= 401, "R10 rate 11", n, 400);
    wrCtrl(8'h10); countEdges(800, n);
    check(n >= 99 && n <= 101, "R10 rate 10", n, 100);
    wrCtrl(8'h08); countEdges(800, n);
    check(n >= 49 && n <= 51, "R10 rate 01", n, 50);
    // R12 reserved bits and halt
    wrCtrl(8'hF8);
    check(ctrlQ == 8'h98, "R12 reserved bits", ctrlQ, 8'h98);
    countEdges(100, n);
    check(n == 0 && intbOe == 0, "R12 halted square wave", n, 0);
    // R11 fail flag
    check(statusQ[7] == 1, "R11 set by chain off", statusQ[7], 1);
    wrCtrl(8'h18);
    statWr = 1; statWrData = 8'h00; @(negedge clk); statWr = 0;
    check(statusQ[7] == 0, "R11 cleared", statusQ[7], 0);
    oscFail = 1; @(negedge clk); oscFail = 0; @(negedge clk);
    check(statusQ[7] == 1, "R11 set by fail", statusQ[7], 1);
    statWr = 1; statWrData = 8'h00; oscFail = 1; @(negedge clk); statWr = 0; oscFail = 0;
    check(statusQ[7] == 1, "R11 set wins", statusQ[7], 1);

    // directed alarm cases, split routing and both enables
    wrCtrl(8'h1F);
    curSec = 8'h30; curMin = 8'h15; curHour = 8'h08; curDay = 8'h03; curDate = 8'h21;
    a1Sec = 8'h30; a1Min = 8'h15; a1Hour = 8'h08; a1DayDate = 8'h43;
    a2Min = 8'h80; a2Hour = 8'h80; a2DayDate = 8'h80;
    // R2: no strobe, no flag
    clrFlags(); repeat (5) @(negedge clk);
    check(statusQ[1:0] == 0, "R2 no tick no flag", statusQ[1:0], 0);
    alarmCase("R5 day select match");
    a1DayDate = 8'h03; alarmCase("R5 date select miss");
    a1DayDate = 8'h21; alarmCase("R5 date select match");
    a1Hour = 8'h48; alarmCase("R6 hour mode differs");
    a1Hour = 8'h08; a1Sec = 8'hB0; alarmCase("R3 illegal mask 0001");
    a1Sec = 8'h30; a1Min = 8'h95; a1DayDate = 8'hA1; alarmCase("R3 illegal mask 1010");
    curSec = 8'h00; a2Min = 8'h15; alarmCase("R4 minutes at second 00");
    curSec = 8'h01; alarmCase("R4 not at second 01");
    // R7 clear versus match in same cycle, and write 1 keeps
    curSec = 8'h00; a1Sec = 8'h80; a1Min = 8'h80; a1Hour = 8'h80; a1DayDate = 8'h80;
    clrFlags(); tick();
    statWr = 1; statWrData = 8'hFF; @(negedge clk); statWr = 0;
    check(statusQ[1:0] == 2'b11, "R7 write one keeps", statusQ[1:0], 3);
    statWr = 1; statWrData = 8'h00; secTick = 1; @(negedge clk); statWr = 0; secTick = 0;
    check(statusQ[1:0] == 2'b11, "R7 set wins over clear", statusQ[1:0], 3);
    statWr = 1; statWrData = 8'h80; @(negedge clk); statWr = 0;
    check(statusQ[1:0] == 2'b00, "R7 clear", statusQ[1:0], 0);
    // R8 shared routing: alarm 2 on INTA, square wave on second pin
    wrCtrl(8'h1A); a1Sec = 8'h00; tick();
    check(intaOe == 1, "R8 shared inta from alarm 2", intaOe, 1);
    countEdges(40, n);
    check(n >= 19, "R8 square on second pin", n, 20);
    wrCtrl(8'h18);
    check(intaOe == 0, "R9 enables off", intaOe, 0);

    // constrained random
    for (int it = 0; it < 300; it++) begin
      logic [7:0] rs, rm, rh;
      rs = bcd($urandom_range(0, 59));
      if ($urandom_range(0, 3) == 0) rs = 8'h00;
      rm = bcd($urandom_range(0, 59));
      rh = bcd($urandom_range(0, 23));
      curSec = rs; curMin = rm; curHour = rh;
      curDay = 8'($urandom_range(1, 7)); curDate = bcd($urandom_range(1, 31));
      if ($urandom_range(0, 1) == 1) begin
        a1Sec = rs; a1Min = rm; a1Hour = rh;
        a1DayDate = $urandom_range(0, 1) ? (8'h40 | curDay) : curDate;
        a2Min = rm; a2Hour = rh;
        a2DayDate = $urandom_range(0, 1) ? (8'h40 | curDay) : curDate;
      end else begin
        a1Sec = bcd($urandom_range(0, 59)); a1Min = bcd($urandom_range(0, 59));
        a1Hour = bcd($urandom_range(0, 23)); a1DayDate = bcd($urandom_range(1, 31));
        a2Min = bcd($urandom_range(0, 59)); a2Hour = bcd($urandom_range(0, 23));
        a2DayDate = 8'($urandom_range(1, 7)) | 8'h40;
      end
      a1Sec[7] = 1'($urandom); a1Min[7] = 1'($urandom);
      a1Hour[7] = 1'($urandom); a1DayDate[7] = 1'($urandom);
      a2Min[7] = 1'($urandom); a2Hour[7] = 1'($urandom); a2DayDate[7] = 1'($urandom);
      wrCtrl({5'b00011, 3'($urandom)});
      alarmCase("R2 R4 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule